// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static memory of 8K words by 8 bits that has an active-low chip select and an active-high chip enable. The host hands over one word at a time: a valid strobe, a direction flag, a 13-bit address and, for writes, a data byte. The sequencer then produces the memory pin waveforms with its own clock. It holds the address steady, lowers the selects, pulses output enable or write enable for long enough, and returns the bus to idle. A read returns its byte with a one-cycle done strobe. A write also ends with that strobe.

Every phase length is derived when the block is elaborated. The clock period and the memory's nanosecond limits are parameters, and each limit is rounded up to whole cycles. One netlist can therefore serve a fast or a slow memory grade, or a different clock, without any edits. The address moves only while the memory is deselected and write enable is high. The data bus driver is released for at least one cycle after any read before a write may drive it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the pins are idle: mem_cs_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dout_en=0, req_ready=1, rsp_done=0.
- R2: A read accepted on a clock edge (req_valid=1, req_write=0, req_ready=1) gives one select cycle (cs_n=0, ce=1, oe_n=1, we_n=1). It is followed by N_RD cycles with oe_n=0, then N_RREC recovery cycles with every strobe inactive, and then idle.
- R3: The read byte is the value on mem_din at the clock edge that ends the last oe_n=0 cycle. It appears on rsp_rdata together with a single-cycle rsp_done=1 in the first recovery cycle, and it holds until the next read completes.
- R4: An accepted write (req_write=1) gives one select cycle, then N_WR cycles with we_n=0, mem_dout_en=1 and mem_dout equal to the request byte, then one recovery cycle, then idle. It pulses rsp_done in the recovery cycle. mem_dout_en is 1 only in cycles where we_n=0.
- R5: mem_addr takes the request address at the accepting edge. It changes only on an edge where we_n was 1 in the cycle before and is 1 in the cycle after.
- R6: mem_dout_en and oe_n=0 never coincide. The cycle after any oe_n=0 cycle has mem_dout_en=0.
- R7: req_ready is 0 from the accepting edge until the access returns to idle. A request presented while req_ready=0 has no effect on the memory.
- R8: Each phase count is the ceiling of nanoseconds over CLK_NS, with a minimum of 1. N_RD is the largest of ceil(access), ceil(output-enable access) and ceil(read cycle)-1. N_WR is the largest of ceil(write pulse), ceil(data setup), ceil(address-to-end-of-write)-1 and ceil(write cycle)-2. N_RREC is ceil(bus release). With the defaults (20 ns clock, fast grade) these give N_RD=4, N_WR=2 and N_RREC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge if valid |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 13 | Memory address pins |
| mem_dout | output | 8 | Byte for the data bus driver |
| mem_din | input | 8 | Byte received from the data bus |
| mem_dout_en | output | 1 | Data bus driver enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench sweeps every eighth address of the 8K space in three passes. It reads the preset pattern, writes a second pattern computed from the address, and reads that pattern back, so each address sees a read directly after a write and a write directly after a read. The memory model in the bench shows the complement of the stored byte until oe_n has been low for N_RD cycles. A capture made one cycle early therefore returns the wrong value and is told apart from a correct one. Some accesses have a conflicting write presented while the sequencer is busy. A later read of the targeted neighbour shows whether that write leaked into the memory. Every cycle of each access is compared against the expected phase pattern, which exposes any phase that is too short or too long.

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl #(
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 65,
  parameter int T_OE_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20,
  parameter int AW      = 13,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  input  logic [DW-1:0] mem_din,
  output logic          mem_dout_en,
  output logic          mem_cs_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD   = mx(mx(cyc(T_AA_NS), cyc(T_OE_NS)), cyc(T_RC_NS) - 1);
  localparam int N_WR   = mx(mx(cyc(T_WP_NS), cyc(T_DW_NS)),
                             mx(cyc(T_AW_NS) - 1, cyc(T_WC_NS) - 2));
  localparam int N_RREC = cyc(T_HZ_NS);
  localparam int N_WREC = 1;
  localparam int N_MAX  = mx(mx(N_RD, N_WR), N_RREC);
  localparam int CW     = $clog2(N_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOVER} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          is_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          is_wr   <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          st      <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt <= is_wr ? CW'(N_WR - 1) : CW'(N_RD - 1);
          st  <= ST_ACTIVE;
        end
        ST_ACTIVE: if (cnt == '0) begin
          if (!is_wr) rdata_q <= mem_din;
          done_q <= 1'b1;
          cnt    <= is_wr ? CW'(N_WREC - 1) : CW'(N_RREC - 1);
          st     <= ST_RECOVER;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) st <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  wire sel = (st == ST_SETUP) || (st == ST_ACTIVE);
  wire act = (st == ST_ACTIVE);

  assign req_ready   = (st == ST_IDLE);
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_cs_n    = !sel;
  assign mem_ce      = sel;
  assign mem_we_n    = !(act && is_wr);
  assign mem_oe_n    = !(act && !is_wr);
  assign mem_dout_en = act && is_wr;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dout_en,
  input logic          mem_cs_n,
  input logic          mem_ce,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  assert_oe_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (!mem_we_n && !mem_cs_n && mem_ce));

  assert_addr_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dout_en);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.AW(AW)) chk_i (.*);

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

  localparam int CLK   = 20;
  localparam int NRD   = (65 + CLK - 1) / CLK;
  localparam int NWR   = (40 + CLK - 1) / CLK;
  localparam int NRREC = (20 + CLK - 1) / CLK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata, mem_dout, mem_din;
  logic [12:0] mem_addr;
  logic        mem_dout_en, mem_cs_n, mem_ce, mem_we_n, mem_oe_n;

  int checks = 0;
  int errors = 0;
  int oe_cyc = 0;
  logic [7:0] bmem [0:8191];

  always #10 clk = ~clk;

  sram_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en),
    .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  function automatic logic [7:0] pre_pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] new_pat(input int a);
    return 8'(a * 7 + 3) ^ 8'(a >> 8);
  endfunction

  initial for (int i = 0; i < 8192; i++) bmem[i] = pre_pat(i);

  always @(posedge clk)
    if (!mem_cs_n && mem_ce && !mem_we_n && mem_dout_en) bmem[mem_addr] <= mem_dout;

  always @(negedge clk) oe_cyc <= mem_oe_n ? 0 : oe_cyc + 1;

  assign mem_din = (oe_cyc >= NRD && !mem_cs_n && mem_ce) ? bmem[mem_addr] : ~bmem[mem_addr];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string tag);
    check({tag, " cs_n"}, mem_cs_n, 1);
    check({tag, " ce"}, mem_ce, 0);
    check({tag, " we_n"}, mem_we_n, 1);
    check({tag, " oe_n"}, mem_oe_n, 1);
    check({tag, " dout_en"}, mem_dout_en, 0);
    check({tag, " ready"}, req_ready, 1);
    check({tag, " done"}, rsp_done, 0);
  endtask

  task automatic run(input bit wr, input int a, input logic [7:0] d, input bit poke);
    int n;
    int rec;
    n = wr ? NWR : NRD;
    rec = wr ? 1 : NRREC;
    @(negedge clk);
    check("R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = 13'(a); req_wdata = wr ? d : 8'h00;
    @(negedge clk);
    req_valid = poke;
    if (poke) begin req_write = 1'b1; req_addr = 13'(a ^ 1); req_wdata = 8'hEE; end
    check("R2 setup cs_n", mem_cs_n, 0);
    check("R2 setup ce", mem_ce, 1);
    check("R2 setup oe_n", mem_oe_n, 1);
    check("R4 setup we_n", mem_we_n, 1);
    check("R4 setup dout_en", mem_dout_en, 0);
    check("R7 busy", req_ready, 0);
    check("R5 address", mem_addr, a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8 active cs_n", mem_cs_n, 0);
      check("R2 active oe_n", mem_oe_n, wr ? 1 : 0);
      check("R4 active we_n", mem_we_n, wr ? 0 : 1);
      check("R4 active dout_en", mem_dout_en, wr ? 1 : 0);
      if (wr) check("R4 write data", mem_dout, d);
      check("R5 address held", mem_addr, a);
    end
    req_valid = 1'b0;
    for (int i = 0; i < rec; i++) begin
      @(negedge clk);
      check("R8 recover cs_n", mem_cs_n, 1);
      check("R6 recover oe_n", mem_oe_n, 1);
      check("R6 recover dout_en", mem_dout_en, 0);
      check("R7 recover busy", req_ready, 0);
      check("R3 done strobe", rsp_done, (i == 0) ? 1 : 0);
      if (!wr && i == 0) check("R3 read data", rsp_rdata, d);
    end
    @(negedge clk);
    idle_chk("R1 after access");
    if (!wr) check("R3 data held", rsp_rdata, d);
  endtask

  initial begin
    #(CLK * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 reset");
    check("R3 reset data", rsp_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 released");
    check("R8 counts", NRD * 100 + NWR * 10 + NRREC, 421);
    for (int a = 0; a < 8192; a += 8) begin
      run(1'b0, a, pre_pat(a), 1'b0);
      run(1'b1, a, new_pat(a), (a % 64) == 0);
      run(1'b0, a, new_pat(a), (a % 128) == 8);
    end
    for (int a = 0; a < 8192; a += 64) begin
      run(1'b0, a ^ 1, pre_pat(a ^ 1), 1'b0);
      run(1'b0, (a + 8) ^ 1, pre_pat((a + 8) ^ 1), 1'b0);
    end
    run(1'b1, 8191, 8'hFF, 1'b0);
    run(1'b1, 8190, 8'h00, 1'b0);
    run(1'b0, 8191, 8'hFF, 1'b0);
    run(1'b0, 8190, 8'h00, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule